// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Controller

This block turns single read or write requests from inside the chip into cycles on an external bus whose low byte lines carry the address first and the data after it. Every bus cycle has two bus phases. In the address phase (T1) the address strobe frames a valid address on both the low and the high byte ports. In the data phase (T2) the data strobe frames a data transfer on the low byte port. The high byte port keeps the upper address until the next cycle starts.

The block runs on a clock at twice the bus phase rate. Each bus phase is two clock cycles long. A strobe is low in the first of those two cycles and high in the second, which gives it a half-phase low pulse. A requester raises `reqValid` with the direction, address and write byte while `busy` is low. One clock after T2 ends, `done` pulses, and for a read `rdData` holds the captured byte. The low byte port is split into an output, an output enable and an input, so that a pad ring or a bench can build the tristate from them.

Top module: `muxBusCtrl`

## Requirements
- R1: While reset is held and right after it: `asN`=1, `dsN`=1, `rdWrN`=1, `lowBusOe`=0, `busy`=0, `done`=0, `rdData`=0.
- R2: A request with `busy` low is taken at the clock edge. In the next cycle `asN`=0, `busy`=1, `highAddr`=address[15:8], `lowBusOut`=address[7:0] and `lowBusOe`=1.
- R3: `asN` is low for exactly one clock. The address on both ports is still driven in the following cycle, when `asN` has returned high.
- R4: `dsN` goes low exactly two clocks after `asN` fell and stays low for one clock. `dsN` is never low outside an access, so with no request it stays high.
- R5: `rdWrN` is 1 for a read and 0 for a write. It takes its value in the first T1 cycle and holds it through T2 and until the next access is taken.
- R6: In a read, `lowBusOe` drops to 0 in the cycle where `dsN` falls and stays 0 until the next access is taken.
- R7: In a read, the byte on `lowBusIn` at the clock edge where `dsN` rises is captured. Any change to `lowBusIn` after that edge has no effect on `rdData`.
- R8: In a write, `lowBusOut` carries the write byte with `lowBusOe`=1 from the cycle where `dsN` falls. It stays on the bus until the next access is taken.
- R9: `highAddr` changes only when a new access is taken.
- R10: `done` is high for exactly one clock, in the cycle after the second T2 cycle. In that cycle `busy`=0, and for a read `rdData` holds the captured byte. A write leaves `rdData` unchanged.
- R11: A request raised while `busy`=1 is ignored. It starts no cycle and alters neither the address ports nor the direction line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per bus phase |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Byte to write |
| busy | output | 1 | Cycle in progress; requests ignored |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Byte captured by the last read |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rdWrN | output | 1 | Direction: 1 read, 0 write |
| lowBusOut | output | 8 | Low byte port output value |
| lowBusOe | output | 1 | Low byte port output enable |
| lowBusIn | input | 8 | Low byte port input value |
| highAddr | output | 8 | Upper address port |

## Verification
Take the edge that accepts a request as edge k. The address outputs and `asN`=0 appear one clock after k. `asN` is high again after two clocks, and `dsN` falls after three clocks along with the turnaround or write data. `dsN` rises and the read byte is captured on the fourth edge. `done` appears after five clocks and is gone after six. The bench drives inputs and samples outputs on falling clock edges, and it checks each result at exactly the falling edge that follows the edge at which that result is due. It also changes `lowBusIn` right after the capture edge and raises a clashing request while `busy` is high, so that a late capture or a wrongly accepted request shows up at the ports.

// File: rtl/muxBusPkg.sv
package muxBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA_LO,
    ST_DATA_HI
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // take a new request
    logic toData;   // move to data phase
    logic capture;  // data strobe rising edge
  } dpCtrl_t;

endpackage

// File: rtl/muxBusCtrlFsm.sv
module muxBusCtrlFsm
  import muxBusPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    busy,
  output logic    done,
  output logic    asN,
  output logic    dsN,
  output dpCtrl_t dpCtrl
);

  busState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      asN   <= 1'b1;
      dsN   <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_ADDR_LO;
            asN   <= 1'b0;
          end
        end
        ST_ADDR_LO: begin
          state <= ST_ADDR_HI;
          asN   <= 1'b1;
        end
        ST_ADDR_HI: begin
          state <= ST_DATA_LO;
          dsN   <= 1'b0;
        end
        ST_DATA_LO: begin
          state <= ST_DATA_HI;
          dsN   <= 1'b1;
        end
        ST_DATA_HI: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    dpCtrl.start   = (state == ST_IDLE) && reqValid;
    dpCtrl.toData  = (state == ST_ADDR_HI);
    dpCtrl.capture = (state == ST_DATA_LO);
  end

endmodule

// File: rtl/muxBusDatapath.sv
module muxBusDatapath
  import muxBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] lowBusIn,
  output logic [DATA_W-1:0] lowBusOut,
  output logic              lowBusOe,
  output logic [HI_W-1:0]   highAddr,
  output logic              rdWrN,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] wdataHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highAddr  <= '0;
      wdataHold <= '0;
      rdWrN     <= 1'b1;
      lowBusOut <= '0;
      lowBusOe  <= 1'b0;
      rdData    <= '0;
    end else begin
      if (dpCtrl.start) begin
        highAddr  <= reqAddr[ADDR_W-1:DATA_W];
        lowBusOut <= reqAddr[DATA_W-1:0];
        wdataHold <= reqWdata;
        rdWrN     <= ~reqWrite;
        lowBusOe  <= 1'b1;
      end else if (dpCtrl.toData) begin
        if (rdWrN) lowBusOe  <= 1'b0;
        else       lowBusOut <= wdataHold;
      end
      if (dpCtrl.capture && rdWrN) rdData <= lowBusIn;
    end
  end

endmodule

// File: rtl/muxBusCtrl.sv
module muxBusCtrl
  import muxBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              asN,
  output logic              dsN,
  output logic              rdWrN,
  output logic [DATA_W-1:0] lowBusOut,
  output logic              lowBusOe,
  input  logic [DATA_W-1:0] lowBusIn,
  output logic [HI_W-1:0]   highAddr
);

  dpCtrl_t dpCtrl;

  muxBusCtrlFsm uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busy     (busy),
    .done     (done),
    .asN      (asN),
    .dsN      (dsN),
    .dpCtrl   (dpCtrl)
  );

  muxBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .lowBusIn  (lowBusIn),
    .lowBusOut (lowBusOut),
    .lowBusOe  (lowBusOe),
    .highAddr  (highAddr),
    .rdWrN     (rdWrN),
    .rdData    (rdData)
  );

endmodule

// File: rtl/muxBusCtrlChecker.sv
module muxBusCtrlChecker #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            busy,
  input logic            done,
  input logic            asN,
  input logic            dsN,
  input logic            rdWrN,
  input logic            lowBusOe,
  input logic [HI_W-1:0] highAddr
);

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (!asN && busy));

  // R3
  as_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !asN |=> asN);

  // R4
  ds_after_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |=> !dsN);

  // R4
  ds_in_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> busy);

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rdWrN) |-> !lowBusOe);

  // R8
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !rdWrN) |-> lowBusOe);

  // R9
  high_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !busy) |=> $stable(highAddr));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind muxBusCtrl muxBusCtrlChecker #(.HI_W(HI_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .asN      (asN),
  .dsN      (dsN),
  .rdWrN    (rdWrN),
  .lowBusOe (lowBusOe),
  .highAddr (highAddr)
);

// File: tb/muxBusCtrl_test.sv
`timescale 1ns/1ps
module muxBusCtrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  lowBusIn = '0;
  logic        busy, done, asN, dsN, rdWrN, lowBusOe;
  logic [7:0]  rdData, lowBusOut, highAddr;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] lastRd = 8'h00;

  always #2 clk = ~clk;

  muxBusCtrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .asN(asN), .dsN(dsN), .rdWrN(rdWrN),
    .lowBusOut(lowBusOut), .lowBusOe(lowBusOe), .lowBusIn(lowBusIn),
    .highAddr(highAddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [15:0] a,
                        input logic [7:0] wd, input logic [7:0] rb,
                        input bit poke);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);                       // after accept edge k
    chk("R2", "asN", asN, 0);
    chk("R2", "busy", busy, 1);
    chk("R2", "highAddr", highAddr, a[15:8]);
    chk("R2", "lowBusOut", lowBusOut, a[7:0]);
    chk("R2", "lowBusOe", lowBusOe, 1);
    chk("R5", "rdWrN T1", rdWrN, !wr);
    chk("R4", "dsN in T1", dsN, 1);
    reqValid = 1'b0;
    if (poke) begin                       // R11 clashing request while busy
      reqValid = 1'b1; reqWrite = !wr; reqAddr = ~a; reqWdata = ~wd;
    end
    @(negedge clk);                       // k+1
    chk("R3", "asN high", asN, 1);
    chk("R3", "highAddr kept", highAddr, a[15:8]);
    chk("R3", "lowBusOut kept", lowBusOut, a[7:0]);
    chk("R3", "lowBusOe kept", lowBusOe, 1);
    chk("R4", "dsN still high", dsN, 1);
    @(negedge clk);                       // k+2
    chk("R4", "dsN low", dsN, 0);
    chk("R5", "rdWrN T2", rdWrN, !wr);
    chk("R11", "highAddr T2", highAddr, a[15:8]);
    if (wr) begin
      chk("R8", "lowBusOe", lowBusOe, 1);
      chk("R8", "lowBusOut", lowBusOut, wd);
    end else begin
      chk("R6", "lowBusOe", lowBusOe, 0);
    end
    lowBusIn = rb;
    @(negedge clk);                       // k+3, capture happened
    chk("R4", "dsN back high", dsN, 1);
    chk("R10", "done early", done, 0);
    lowBusIn = ~rb;                       // R7 late change must be ignored
    reqValid = 1'b0;
    @(negedge clk);                       // k+4
    if (!wr) lastRd = rb;
    chk("R10", "done", done, 1);
    chk("R10", "busy", busy, 0);
    chk("R7", "rdData", rdData, lastRd);
    chk("R9", "highAddr", highAddr, a[15:8]);
    chk("R5", "rdWrN held", rdWrN, !wr);
    if (wr) chk("R8", "data held", lowBusOut, wd);
    else    chk("R6", "still released", lowBusOe, 0);
    @(negedge clk);                       // k+5
    chk("R10", "done one clock", done, 0);
    chk("R11", "no new cycle", asN, 1);
    chk("R11", "busy idle", busy, 0);
    chk("R11", "highAddr", highAddr, a[15:8]);
    chk("R11", "rdWrN", rdWrN, !wr);
    chk("R4", "dsN idle", dsN, 1);
    chk("R8", "oe after", lowBusOe, wr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "asN in reset", asN, 1);
    chk("R1", "dsN in reset", dsN, 1);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1", "asN", asN, 1);
      chk("R1", "dsN", dsN, 1);
      chk("R1", "rdWrN", rdWrN, 1);
      chk("R1", "lowBusOe", lowBusOe, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "rdData", rdData, 0);
    end
    // walking-one addresses, both directions
    for (int b = 0; b < 16; b++) begin
      access(1'b1, 16'h1 << b, 8'(b * 29 + 3), 8'h00, 1'b0);
      access(1'b0, 16'h1 << b, 8'h00, 8'(8'hA5 ^ b), 1'b0);
    end
    // arithmetic sweep with mixed ordering and clashing requests
    for (int i = 0; i < 48; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h0507 + 16'h1234);
      access(i[0], a, 8'(i * 37), 8'(a[7:0] ^ a[15:8] ^ 8'h5A), i % 3 == 0);
    end
    // back-to-back reads of extreme bytes
    access(1'b0, 16'hFFFF, 8'h00, 8'hFF, 1'b1);
    access(1'b0, 16'h0000, 8'h00, 8'h00, 1'b1);
    access(1'b1, 16'hFF00, 8'hFF, 8'h00, 1'b1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule